// File: doc/BRIEF.md
# DMA Channel Width-Packing FIFO

This block is the data buffer of one DMA channel. It sits between a source port and a destination port. Each port has its own transfer width of 8, 16, 32, 64 or 128 bits. Source beats are written into a byte-addressed store. Destination words are read out once enough bytes are held to fill one word at the destination width. Both ports use plain valid/ready beat handshakes. Bytes are little-endian on both sides, so the lowest lane carries the earliest byte.

The channel can be suspended, resumed and disabled, and it flushes at the end of a block. While suspended, the channel refuses new source beats but keeps draining complete destination words. Clearing suspend loses nothing. Dropping the enable throws away every byte still held. Once the programmed number of block bytes has arrived from the source, the remaining bytes go out as one short word with a byte-enable mask.

The empty flag means "too few bytes to build one destination word". It does not mean the store is truly empty, so a suspended channel can show empty while a few bytes remain. A handshaking peripheral source is admitted one burst at a time: each beat needs room for a whole burst. This keeps the buffer evenly filled when the source width times the burst length covers the destination width.

Top module: `chan_pack_fifo`

## Requirements
- R1: The width codes 0, 1, 2, 3 and 4 on `srcWidth` and `dstWidth` select 1, 2, 4, 8 and 16 bytes per beat. The two ports are set independently, and every pair of codes moves the stream unchanged.
- R2: Byte ordering is little-endian. Lane i of a beat is data bits [8i+7:8i]. The bytes leave the destination in exactly the order they entered the source. Source lanes above the source width are ignored.
- R3: Outside a flush, `dstValid` is high only while the buffer holds at least one full destination word, and each such word carries all of its strobe bits.
- R4: `srcReady` is high only when all four of these hold: the channel is enabled, it is not suspended, fewer than `blockBytes` bytes have been received, and free space is at least the effective burst length times the source width in bytes. Occupancy never exceeds `DEPTH_BYTES`.
- R5: The effective burst length is `srcBurst` when `srcPeriph` is 1 and `srcBurst` is nonzero. It is 1 when `srcBurst` is 0, and also when `srcPeriph` is 0 (a memory source), whatever `srcBurst` holds.
- R6: While `suspend` is high, no source beat is accepted, but complete destination words continue to drain.
- R7: `fifoEmpty` is high when fewer bytes are held than one destination word. During a flush it is high only when no byte is held.
- R8: Clearing `suspend` while enabled keeps every held byte, and the stream resumes with no loss.
- R9: With `enable` low, `dstValid` and `srcReady` are low. At the next clock edge the occupancy and the received-byte count are zero, and any residual bytes are never delivered.
- R10: When the received count reaches `blockBytes`, the remaining bytes leave as one partial word. Its `dstStrb` has the low n bits set, where n is the number of bytes it carries.
- R11: After reset, `srcReady` and `dstValid` are low and `fifoEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; low discards all held bytes |
| suspend | input | 1 | Stop accepting source beats; draining continues |
| srcWidth | input | 3 | Source width code (0 to 4 give 1 to 16 bytes) |
| dstWidth | input | 3 | Destination width code (0 to 4 give 1 to 16 bytes) |
| srcPeriph | input | 1 | 1 when the source is a handshaking peripheral, 0 for memory |
| srcBurst | input | BURST_W | Source burst length in beats; 0 is treated as 1 |
| blockBytes | input | BLK_W | Bytes in the block transfer |
| srcValid | input | 1 | Source beat valid |
| srcData | input | 128 | Source beat data, little-endian lanes |
| srcReady | output | 1 | Source beat accepted when high together with srcValid |
| dstValid | output | 1 | Destination word available |
| dstData | output | 128 | Destination word data, little-endian lanes |
| dstStrb | output | 16 | Valid byte lanes of the destination word |
| dstReady | input | 1 | Destination accepts the word |
| fifoEmpty | output | 1 | Not enough bytes for one destination word (during a flush: no bytes held) |

## Verification
A source push and a destination drain can land on the same clock edge. That edge must add the source bytes and subtract the drained bytes in one step. The last source beat of a block can also coincide with the first flush of a partial word. Both cases are provoked by running every pair of width codes with a continuous source while the destination ready follows a repeating pattern. Each cycle the bench predicts the ready, valid and empty outputs from a byte-queue model of the occupancy, and it compares every word and strobe against that queue. Directed cases cover suspend combined with draining, disable combined with residual bytes, and burst-sized admission.

// File: rtl/pack_fifo_pkg.sv
package pack_fifo_pkg;
  // Widest port: 16 byte lanes (128 bits)
  localparam int unsigned LANES  = 16;
  localparam int unsigned LANE_W = $clog2(LANES + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic              clear;
    logic              push;
    logic              pop;
    logic [LANE_W-1:0] pushBytes;
    logic [LANE_W-1:0] popBytes;
  } fifoStrobes_t;

  // Width code to byte count: 0..4 -> 1..16, larger codes saturate at 16
  function automatic logic [LANE_W-1:0] codeToBytes(input logic [2:0] code);
    case (code)
      3'd0:    codeToBytes = LANE_W'(1);
      3'd1:    codeToBytes = LANE_W'(2);
      3'd2:    codeToBytes = LANE_W'(4);
      3'd3:    codeToBytes = LANE_W'(8);
      default: codeToBytes = LANE_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/pack_fifo_ctrl.sv
module pack_fifo_ctrl
  import pack_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 32,
  parameter int unsigned BLK_W       = 16,
  parameter int unsigned BURST_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               suspend,
  input  logic [2:0]         srcWidth,
  input  logic [2:0]         dstWidth,
  input  logic               srcPeriph,
  input  logic [BURST_W-1:0] srcBurst,
  input  logic [BLK_W-1:0]   blockBytes,
  input  logic               srcValid,
  input  logic               dstReady,
  output logic               srcReady,
  output logic               dstValid,
  output logic               fifoEmpty,
  output fifoStrobes_t       strobes
);
  localparam int unsigned CNT_W = $clog2(DEPTH_BYTES + 1);
  localparam int unsigned BB_W  = BURST_W + LANE_W;

  logic [CNT_W-1:0]   count;
  logic [BLK_W:0]     rcvd;
  logic [LANE_W-1:0]  srcBytes, dstBytes, popBytes;
  logic [BURST_W-1:0] effBurst;
  logic [BB_W-1:0]    burstBytes;
  logic [CNT_W-1:0]   freeBytes;
  logic               flushing, fullWord, pushFire, popFire;

  always_comb begin
    srcBytes   = codeToBytes(srcWidth);
    dstBytes   = codeToBytes(dstWidth);
    // burst length applies only to a handshaking source; zero means one
    effBurst   = (srcPeriph && srcBurst != '0) ? srcBurst : BURST_W'(1);
    burstBytes = BB_W'(effBurst) * BB_W'(srcBytes);
    freeBytes  = CNT_W'(DEPTH_BYTES) - count;
    flushing   = rcvd >= {1'b0, blockBytes};
    fullWord   = 32'(count) >= 32'(dstBytes);
    srcReady   = enable && !suspend && !flushing && (32'(freeBytes) >= 32'(burstBytes));
    dstValid   = enable && (fullWord || (flushing && count != '0));
    popBytes   = fullWord ? dstBytes : LANE_W'(count);
    fifoEmpty  = flushing ? (count == '0) : !fullWord;
    pushFire   = srcValid && srcReady;
    popFire    = dstValid && dstReady;
    strobes.clear     = !enable;
    strobes.push      = pushFire;
    strobes.pop       = popFire;
    strobes.pushBytes = srcBytes;
    strobes.popBytes  = popBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      count <= '0;
      rcvd  <= '0;
    end else begin
      count <= count + (pushFire ? CNT_W'(srcBytes) : CNT_W'(0))
                     - (popFire  ? CNT_W'(popBytes) : CNT_W'(0));
      rcvd  <= rcvd + (pushFire ? (BLK_W+1)'(srcBytes) : (BLK_W+1)'(0));
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) <= DEPTH_BYTES);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    popFire |-> (popBytes != '0) && (32'(popBytes) <= 32'(count)));

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (count == '0) && (rcvd == '0));

  // R6
  suspend_nofill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && suspend) |=> count <= $past(count));

  // R8
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !pushFire && !popFire) |=> $stable(count));
endmodule

// File: rtl/pack_fifo_dp.sv
module pack_fifo_dp
  import pack_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 32  // power of two, at least LANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobes_t       strobes,
  input  logic [LANES*8-1:0] srcData,
  output logic [LANES*8-1:0] dstData,
  output logic [LANES-1:0]   dstStrb
);
  localparam int unsigned PTR_W = $clog2(DEPTH_BYTES);

  logic [7:0]       mem [DEPTH_BYTES];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  // byte-lane write: lane i lands at wrPtr + i
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strobes.push && (i < int'(strobes.pushBytes)))
        mem[wrPtr + PTR_W'(i)] <= srcData[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + PTR_W'(strobes.pushBytes);
      if (strobes.pop)  rdPtr <= rdPtr + PTR_W'(strobes.popBytes);
    end
  end

  // read lanes: lane j comes from rdPtr + j, strobe marks the low popBytes lanes
  for (genvar j = 0; j < LANES; j++) begin : g_rdLane
    assign dstData[8*j +: 8] = mem[rdPtr + PTR_W'(j)];
    assign dstStrb[j]        = LANE_W'(j) < strobes.popBytes;
  end
endmodule

// File: rtl/chan_pack_fifo.sv
module chan_pack_fifo
  import pack_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 32,
  parameter int unsigned BLK_W       = 16,
  parameter int unsigned BURST_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               suspend,
  input  logic [2:0]         srcWidth,
  input  logic [2:0]         dstWidth,
  input  logic               srcPeriph,
  input  logic [BURST_W-1:0] srcBurst,
  input  logic [BLK_W-1:0]   blockBytes,
  input  logic               srcValid,
  input  logic [127:0]       srcData,
  output logic               srcReady,
  output logic               dstValid,
  output logic [127:0]       dstData,
  output logic [15:0]        dstStrb,
  input  logic               dstReady,
  output logic               fifoEmpty
);
  fifoStrobes_t strobes;

  pack_fifo_ctrl #(
    .DEPTH_BYTES(DEPTH_BYTES), .BLK_W(BLK_W), .BURST_W(BURST_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .suspend(suspend),
    .srcWidth(srcWidth), .dstWidth(dstWidth), .srcPeriph(srcPeriph),
    .srcBurst(srcBurst), .blockBytes(blockBytes), .srcValid(srcValid),
    .dstReady(dstReady), .srcReady(srcReady), .dstValid(dstValid),
    .fifoEmpty(fifoEmpty), .strobes(strobes)
  );

  pack_fifo_dp #(.DEPTH_BYTES(DEPTH_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcData(srcData),
    .dstData(dstData), .dstStrb(dstStrb)
  );

  // R10
  strb_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    dstValid |-> (dstStrb != '0) && ((({1'b0, dstStrb} + 17'd1) & {1'b0, dstStrb}) == 17'd0));
endmodule

// File: tb/chan_pack_fifo_tb.sv
`timescale 1ns/1ps
module chan_pack_fifo_tb;
  localparam int DEPTH = 32;

  logic         clk = 0;
  logic         rstN = 0;
  logic         enable = 0, suspend = 0, srcPeriph = 0;
  logic [2:0]   srcWidth = 0, dstWidth = 0;
  logic [3:0]   srcBurst = 0;
  logic [15:0]  blockBytes = 0;
  logic         srcValid = 0, dstReady = 0;
  logic [127:0] srcData = 0;
  logic         srcReady, dstValid, fifoEmpty;
  logic [127:0] dstData;
  logic [15:0]  dstStrb;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chan_pack_fifo #(.DEPTH_BYTES(DEPTH), .BLK_W(16), .BURST_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .suspend(suspend),
    .srcWidth(srcWidth), .dstWidth(dstWidth), .srcPeriph(srcPeriph),
    .srcBurst(srcBurst), .blockBytes(blockBytes), .srcValid(srcValid),
    .srcData(srcData), .srcReady(srcReady), .dstValid(dstValid),
    .dstData(dstData), .dstStrb(dstStrb), .dstReady(dstReady),
    .fifoEmpty(fifoEmpty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k, int sw, int dw);
    return 8'((k * 7 + sw * 13 + dw * 5 + 1) & 255);
  endfunction

  // all lane/width pairs; R1 R2 R3 R4 R7 R10
  task automatic runCombo(int sw, int dw);
    int sB, dB, blk, sent, got, cyc, n;
    logic [7:0] q[$];
    logic [127:0] expD, mask;
    bit expR, expE, expV;
    sB = 1 << sw; dB = 1 << dw; blk = (sw == 4) ? 48 : 40;
    enable = 0; srcValid = 0; dstReady = 0; suspend = 0;
    srcWidth = 3'(sw); dstWidth = 3'(dw); srcPeriph = 0; srcBurst = 0;
    blockBytes = 16'(blk);
    @(posedge clk); #1;
    enable = 1; sent = 0; got = 0; cyc = 0;
    srcValid = 1; srcData = {16{8'hAA}};
    for (int k = 0; k < sB; k++) srcData[8*k +: 8] = pat(k, sw, dw);
    dstReady = 1;
    while (got < blk && cyc < 3000) begin
      @(negedge clk);
      expR = (sent < blk) && ((DEPTH - q.size()) >= sB);
      check(srcReady == expR, "R4", "srcReady", 128'(srcReady), 128'(expR));
      expE = (sent >= blk) ? (q.size() == 0) : (q.size() < dB);
      check(fifoEmpty == expE, "R7", "fifoEmpty", 128'(fifoEmpty), 128'(expE));
      expV = (q.size() >= dB) || (sent >= blk && q.size() > 0);
      check(dstValid == expV, "R3", "dstValid", 128'(dstValid), 128'(expV));
      if (dstValid && dstReady) begin
        n = (q.size() >= dB) ? dB : q.size();
        expD = '0; mask = '0;
        for (int k = 0; k < n; k++) begin
          expD[8*k +: 8] = q[k];
          mask[8*k +: 8] = 8'hFF;
        end
        check((dstData & mask) == expD, "R2", "dstData", dstData & mask, expD);
        check(dstStrb == 16'((17'd1 << n) - 17'd1), (n < dB) ? "R10" : "R1",
              "dstStrb", 128'(dstStrb), 128'((17'd1 << n) - 17'd1));
        for (int k = 0; k < n && q.size() > 0; k++) void'(q.pop_front());
        got += n;
      end
      if (srcValid && srcReady) begin
        for (int k = 0; k < sB; k++) q.push_back(pat(sent + k, sw, dw));
        sent += sB;
      end
      @(posedge clk); #1;
      cyc++;
      srcValid = (sent < blk);
      srcData = {16{8'hAA}};
      for (int k = 0; k < sB; k++) srcData[8*k +: 8] = pat(sent + k, sw, dw);
      dstReady = (cyc % 3) != 2;
    end
    check(got == blk, "R1", "bytes delivered", 128'(got), 128'(blk));
  endtask

  task automatic pushByte(logic [7:0] v);
    srcData = {15'd0, v} | 128'(v);
    srcValid = 1;
    @(negedge clk);
    while (!srcReady) @(negedge clk);
    @(posedge clk); #1;
    srcValid = 0;
  endtask

  // burst admission: fill with a blocked destination; R5
  task automatic fillTest(bit periph, int burst, int expCount, string req);
    int acc;
    enable = 0; suspend = 0; dstReady = 0; srcValid = 0;
    srcWidth = 0; dstWidth = 4; srcPeriph = periph; srcBurst = 4'(burst);
    blockBytes = 16'd1000;
    @(posedge clk); #1;
    enable = 1; srcValid = 1; srcData = 128'h5A; acc = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (srcValid && srcReady) acc++;
      @(posedge clk); #1;
    end
    srcValid = 0;
    check(acc == expCount, req, "bytes admitted", 128'(acc), 128'(expCount));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R11 reset state
    check(srcReady == 0, "R11", "srcReady", 128'(srcReady), 0);
    check(dstValid == 0, "R11", "dstValid", 128'(dstValid), 0);
    check(fifoEmpty == 1, "R11", "fifoEmpty", 128'(fifoEmpty), 1);
    @(posedge clk); #1;
    rstN = 1;
    @(posedge clk); #1;

    for (int sw = 0; sw < 5; sw++)
      for (int dw = 0; dw < 5; dw++)
        runCombo(sw, dw);

    // suspend, resume and disable with 8-bit source and 32-bit destination
    enable = 0; srcValid = 0; dstReady = 0; suspend = 0;
    srcWidth = 0; dstWidth = 2; srcPeriph = 0; srcBurst = 0; blockBytes = 16'd64;
    @(posedge clk); #1;
    enable = 1;
    for (int k = 0; k < 6; k++) pushByte(8'(8'h10 + k));
    suspend = 1; dstReady = 1; srcValid = 1; srcData = 128'hEE;
    @(negedge clk);
    check(srcReady == 0, "R6", "srcReady while suspended", 128'(srcReady), 0);
    check(dstValid == 1, "R6", "drain while suspended", 128'(dstValid), 1);
    check(dstData[31:0] == 32'h13121110, "R6", "drained word", 128'(dstData[31:0]), 128'h13121110);
    @(posedge clk); #1;
    @(negedge clk);
    check(dstValid == 0, "R7", "no word from 2 bytes", 128'(dstValid), 0);
    check(fifoEmpty == 1, "R7", "empty with residual", 128'(fifoEmpty), 1);
    check(srcReady == 0, "R6", "srcReady still blocked", 128'(srcReady), 0);
    @(posedge clk); #1;
    srcValid = 0; suspend = 0; dstReady = 0;
    pushByte(8'h16); pushByte(8'h17);
    @(negedge clk);
    check(dstValid == 1, "R8", "word after resume", 128'(dstValid), 1);
    check(dstData[31:0] == 32'h17161514, "R8", "residual kept", 128'(dstData[31:0]), 128'h17161514);
    dstReady = 1;
    @(posedge clk); #1;
    dstReady = 0;
    pushByte(8'h18); pushByte(8'h19);
    suspend = 1; enable = 0;
    @(negedge clk);
    check(dstValid == 0, "R9", "dstValid while disabled", 128'(dstValid), 0);
    check(srcReady == 0, "R9", "srcReady while disabled", 128'(srcReady), 0);
    @(posedge clk); #1;
    enable = 1; suspend = 0;
    @(negedge clk);
    check(fifoEmpty == 1, "R9", "empty after disable", 128'(fifoEmpty), 1);
    check(dstValid == 0, "R9", "nothing left after disable", 128'(dstValid), 0);
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) pushByte(8'(8'hC0 + k));
    @(negedge clk);
    check(dstValid == 1, "R9", "fresh word valid", 128'(dstValid), 1);
    check(dstData[31:0] == 32'hC3C2C1C0, "R9", "residual discarded", 128'(dstData[31:0]), 128'hC3C2C1C0);
    @(posedge clk); #1;

    // R5 burst-sized admission, depth 32, 1-byte beats
    fillTest(1, 5, 28, "R5");
    fillTest(1, 3, 30, "R5");
    fillTest(1, 0, 32, "R5");
    fillTest(0, 5, 32, "R5");
    fillTest(1, 1, 32, "R4");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule